// File: doc/BRIEF.md
# Two-Level Dispatch ALU

This block is the arithmetic and logic unit of a small multicycle processor with a 32-bit datapath. It is purely combinational. The sequencer supplies a master operation code. Most codes name an operation directly. One code, "dispatch", hands the choice to the 6-bit function field of the current register-format instruction. Beside the main path, a small side decoder maps the primary opcode of an immediate-arithmetic instruction to the master code that the sequencer should issue for it.

The unit adds, subtracts, ANDs, ORs and NORs its two operands, and performs a signed set-on-less-than. Its two shifts move operand B, not operand A, by the instruction's 5-bit shift amount. A pass-through returns operand A, and a "none" code yields zero. Add and subtract wrap modulo 2^32 and report no overflow. A zero flag follows the result. An illegal-operation output rises when the function field or the master code names nothing the unit implements, and the result is then forced to zero.

Top module: `dispatch_alu`

## Requirements
- R1: Master codes (4-bit `master_op`) 2=add, 3=sub, 4=and, 5=or and 6=nor apply directly to A and B. Add and sub wrap modulo 2^32.
- R2: Master code 1 (dispatch) picks the operation from `funct` as follows: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x27 nor, 0x2A slt, 0x00 sll, 0x02 srl.
- R3: The slt operation (master code 7, or funct 0x2A under dispatch) compares A and B as signed two's-complement values. It returns 1 when A < B and 0 otherwise.
- R4: The sll operation (code 8) returns B shifted left by `shamt`. The srl operation (code 9) returns B shifted right logically by `shamt`, filling with zeros. Operand A plays no part in either shift.
- R5: Master code 10 (pass-A) returns A unchanged. Master code 0 (none) returns 0.
- R6: `zero` is 1 exactly when the 32-bit result equals 0.
- R7: `imm_op` maps `imm_opcode` 0x08 to 2 (add), 0x0C to 4 (and) and 0x0D to 5 (or). Every other opcode maps to 0 (none).
- R8: Under dispatch, a `funct` value outside the list in R2 drives the result to 0 and `illegal` to 1. For master codes 0 to 10 with a listed `funct`, `illegal` is 0.
- R9: Master codes 11 to 15 drive the result to 0 and `illegal` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| master_op | input | 4 | Master operation code from the sequencer |
| funct | input | 6 | Function field of the instruction |
| shamt | input | 5 | Shift amount field |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| imm_opcode | input | 6 | Primary opcode for immediate-arithmetic mapping |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is zero |
| illegal | output | 1 | Unrecognised funct or master code |
| imm_op | output | 4 | Master code for the immediate opcode |

## Verification
Immediate assertions check a set of rules whenever the inputs change. An illegal flag always comes with a zero result. Pass-A always echoes A, and none always gives zero. slt only ever produces 0 or 1. A logical right shift by a non-zero amount never sets the top bit. Whether each operation computes the right value needs the bench's scenarios, because only a model written out separately can judge that. These scenarios cover wrapping sums and differences, signed comparisons across the sign boundary, shifts of B with A held at a different value, every listed funct code, unlisted funct codes, the unused master codes and the immediate-opcode mapping.

// File: rtl/alu_ops_pkg.sv
package alu_ops_pkg;
    localparam int OP_W  = 4;
    localparam int FN_W  = 6;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 4'd0,
        OP_DISP  = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_NOR   = 4'd6,
        OP_SLT   = 4'd7,
        OP_SLL   = 4'd8,
        OP_SRL   = 4'd9,
        OP_PASSA = 4'd10
    } op_e;

    localparam logic [FN_W-1:0] FN_SLL = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL = 6'h02;
    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_NOR = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    localparam logic [FN_W-1:0] IMM_ADD = 6'h08;
    localparam logic [FN_W-1:0] IMM_AND = 6'h0C;
    localparam logic [FN_W-1:0] IMM_OR  = 6'h0D;

    typedef struct packed {
        op_e  op;
        logic bad;
    } dec_t;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_ops_pkg::*;
(
    input  logic [OP_W-1:0] master_op,
    input  logic [FN_W-1:0] funct,
    output op_e             exec_op,
    output logic            bad_op
);
    dec_t dec_d;

    always_comb begin
        dec_d = '{op: OP_NONE, bad: 1'b0};
        if (master_op == OP_DISP) begin
            unique case (funct)
                FN_ADD:  dec_d.op = OP_ADD;
                FN_SUB:  dec_d.op = OP_SUB;
                FN_AND:  dec_d.op = OP_AND;
                FN_OR:   dec_d.op = OP_OR;
                FN_NOR:  dec_d.op = OP_NOR;
                FN_SLT:  dec_d.op = OP_SLT;
                FN_SLL:  dec_d.op = OP_SLL;
                FN_SRL:  dec_d.op = OP_SRL;
                default: dec_d.bad = 1'b1;
            endcase
        end else if (master_op > OP_PASSA) begin
            dec_d.bad = 1'b1;
        end else begin
            dec_d.op = op_e'(master_op);
        end
    end

    assign exec_op = dec_d.op;
    assign bad_op  = dec_d.bad;

    // r2 / r8: a resolved operation is never the dispatch code itself
    always_comb begin
        a_r2_resolved: assert (exec_op != OP_DISP);
    end
endmodule

// File: rtl/alu_imm_map.sv
module alu_imm_map
    import alu_ops_pkg::*;
(
    input  logic [FN_W-1:0] opcode,
    output logic [OP_W-1:0] imm_op
);
    op_e map_d;

    always_comb begin
        unique case (opcode)
            IMM_ADD: map_d = OP_ADD;
            IMM_AND: map_d = OP_AND;
            IMM_OR:  map_d = OP_OR;
            default: map_d = OP_NONE;
        endcase
    end

    assign imm_op = map_d;

    // R7: the map only ever yields none, add, and, or
    always_comb begin
        a_r7_imm_range: assert (map_d == OP_NONE || map_d == OP_ADD ||
                                map_d == OP_AND  || map_d == OP_OR);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_ops_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  op_e                op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [WIDTH-1:0]   res
);
    logic [WIDTH-1:0] res_d;
    logic             lt_d;

    always_comb begin
        lt_d = ($signed(a) < $signed(b));
        case (op)
            OP_ADD:   res_d = a + b;
            OP_SUB:   res_d = a - b;
            OP_AND:   res_d = a & b;
            OP_OR:    res_d = a | b;
            OP_NOR:   res_d = ~(a | b);
            OP_SLT:   res_d = {{(WIDTH-1){1'b0}}, lt_d};
            OP_SLL:   res_d = b << shamt;
            OP_SRL:   res_d = b >> shamt;
            OP_PASSA: res_d = a;
            default:  res_d = '0;
        endcase
    end

    assign res = res_d;

    // R3: slt yields only 0 or 1
    always_comb begin
        if (op == OP_SLT) a_r3_slt_bool: assert (res[WIDTH-1:1] == '0);
    end

    // R4: a logical right shift by a non-zero amount clears the top bit
    always_comb begin
        if (op == OP_SRL && shamt != '0) a_r4_srl_fill: assert (res[WIDTH-1] == 1'b0);
    end
endmodule

// File: rtl/dispatch_alu.sv
module dispatch_alu
    import alu_ops_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [3:0]         master_op,
    input  logic [5:0]         funct,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    input  logic [5:0]         imm_opcode,
    output logic [WIDTH-1:0]   result,
    output logic               zero,
    output logic               illegal,
    output logic [3:0]         imm_op
);
    op_e exec_op;

    alu_op_decode u_dec (
        .master_op (master_op),
        .funct     (funct),
        .exec_op   (exec_op),
        .bad_op    (illegal)
    );

    alu_core #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_core (
        .op    (exec_op),
        .a     (opnd_a),
        .b     (opnd_b),
        .shamt (shamt),
        .res   (result)
    );

    alu_imm_map u_imm (
        .opcode (imm_opcode),
        .imm_op (imm_op)
    );

    assign zero = (result == '0);

    // R8 / R9: an illegal request never leaks a non-zero result
    always_comb begin
        if (illegal) a_r8_illegal_zero: assert (result == '0);
    end

    // R5: pass-A echoes A, none gives zero
    always_comb begin
        if (master_op == OP_PASSA) a_r5_pass_a: assert (result == opnd_a);
        if (master_op == OP_NONE)  a_r5_none: assert (result == '0 && !illegal);
    end
endmodule

// File: tb/dispatch_alu_bench.sv
module dispatch_alu_bench;
    typedef struct {
        logic [31:0] res;
        logic        ill;
        logic [3:0]  imm;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic [3:0]  master_op = '0;
    logic [5:0]  funct = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [5:0]  imm_opcode = '0;
    logic [31:0] result;
    logic        zero, illegal;
    logic [3:0]  imm_op;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    dispatch_alu u_dispatch_alu (
        .master_op(master_op), .funct(funct), .shamt(shamt),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_opcode(imm_opcode),
        .result(result), .zero(zero), .illegal(illegal), .imm_op(imm_op)
    );

    task automatic drive(input logic [3:0] m, input logic [5:0] f, input logic [4:0] s,
                         input logic [31:0] a, input logic [31:0] b, input logic [5:0] opc,
                         input logic [31:0] er, input logic ei, input logic [3:0] eimm,
                         input string tag);
        exp_t e;
        @(posedge clk);
        master_op = m; funct = f; shamt = s; opnd_a = a; opnd_b = b; imm_opcode = opc;
        e.res = er; e.ill = ei; e.imm = eimm; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (result !== e.res || zero !== (e.res == 0) || illegal !== e.ill || imm_op !== e.imm) begin
                    errors++;
                    $display("FAIL %s: res=%h zero=%b ill=%b imm=%0d expected res=%h zero=%b ill=%b imm=%0d",
                             e.tag, result, zero, illegal, imm_op, e.res, (e.res == 0), e.ill, e.imm);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        // idle state: none code, all zero
        drive(4'd0, 6'h00, 5'd0, 32'h0, 32'h0, 6'h00, 32'h0, 1'b0, 4'd0, "R5 R6 idle none");
        // R1 direct operations, wrapping
        drive(4'd2, 6'h3F, 5'd0, 32'hFFFF_FFFF, 32'h2, 6'h00, 32'h1, 1'b0, 4'd0, "R1 add wrap");
        drive(4'd3, 6'h3F, 5'd0, 32'h0, 32'h1, 6'h00, 32'hFFFF_FFFF, 1'b0, 4'd0, "R1 sub wrap");
        drive(4'd4, 6'h00, 5'd0, 32'hF0F0_1234, 32'h0FF0_FF00, 6'h00, 32'h00F0_1200, 1'b0, 4'd0, "R1 and");
        drive(4'd5, 6'h00, 5'd0, 32'hF000_0001, 32'h0000_0F00, 6'h00, 32'hF000_0F01, 1'b0, 4'd0, "R1 or");
        drive(4'd6, 6'h00, 5'd0, 32'hF000_0000, 32'h0000_000F, 6'h00, 32'h0FFF_FFF0, 1'b0, 4'd0, "R1 nor");
        drive(4'd3, 6'h00, 5'd0, 32'h1234_5678, 32'h1234_5678, 6'h00, 32'h0, 1'b0, 4'd0, "R6 sub equal zero");
        // R2 dispatch by funct
        drive(4'd1, 6'h20, 5'd0, 32'd7, 32'd5, 6'h00, 32'd12, 1'b0, 4'd0, "R2 funct add");
        drive(4'd1, 6'h22, 5'd0, 32'd7, 32'd5, 6'h00, 32'd2, 1'b0, 4'd0, "R2 funct sub");
        drive(4'd1, 6'h24, 5'd0, 32'hC, 32'hA, 6'h00, 32'h8, 1'b0, 4'd0, "R2 funct and");
        drive(4'd1, 6'h25, 5'd0, 32'hC, 32'hA, 6'h00, 32'hE, 1'b0, 4'd0, "R2 funct or");
        drive(4'd1, 6'h27, 5'd0, 32'hC, 32'hA, 6'h00, 32'hFFFF_FFF1, 1'b0, 4'd0, "R2 funct nor");
        drive(4'd1, 6'h2A, 5'd0, 32'hFFFF_FFFF, 32'd1, 6'h00, 32'd1, 1'b0, 4'd0, "R2 R3 funct slt neg<pos");
        drive(4'd1, 6'h00, 5'd4, 32'hDEAD_BEEF, 32'h0000_00F1, 6'h00, 32'h0000_0F10, 1'b0, 4'd0, "R2 R4 funct sll");
        drive(4'd1, 6'h02, 5'd4, 32'hDEAD_BEEF, 32'h8000_0010, 6'h00, 32'h0800_0001, 1'b0, 4'd0, "R2 R4 funct srl");
        // R3 signed compare
        drive(4'd7, 6'h00, 5'd0, 32'd1, 32'hFFFF_FFFF, 6'h00, 32'd0, 1'b0, 4'd0, "R3 slt pos<neg false");
        drive(4'd7, 6'h00, 5'd0, 32'h8000_0000, 32'h7FFF_FFFF, 6'h00, 32'd1, 1'b0, 4'd0, "R3 slt min<max");
        drive(4'd7, 6'h00, 5'd0, 32'd9, 32'd9, 6'h00, 32'd0, 1'b0, 4'd0, "R3 slt equal");
        // R4 shifts on B
        drive(4'd8, 6'h00, 5'd31, 32'hFFFF_FFFF, 32'h3, 6'h00, 32'h8000_0000, 1'b0, 4'd0, "R4 sll 31");
        drive(4'd9, 6'h00, 5'd31, 32'h0, 32'hFFFF_FFFF, 6'h00, 32'h1, 1'b0, 4'd0, "R4 srl 31 zero fill");
        drive(4'd9, 6'h00, 5'd0, 32'h1, 32'h8000_0000, 6'h00, 32'h8000_0000, 1'b0, 4'd0, "R4 srl by 0");
        // R5
        drive(4'd10, 6'h00, 5'd3, 32'hCAFE_F00D, 32'h1, 6'h00, 32'hCAFE_F00D, 1'b0, 4'd0, "R5 pass-A");
        drive(4'd0, 6'h20, 5'd3, 32'h5, 32'h6, 6'h00, 32'h0, 1'b0, 4'd0, "R5 none ignores operands");
        // R7 immediate map
        drive(4'd0, 6'h00, 5'd0, 32'h0, 32'h0, 6'h08, 32'h0, 1'b0, 4'd2, "R7 imm add");
        drive(4'd0, 6'h00, 5'd0, 32'h0, 32'h0, 6'h0C, 32'h0, 1'b0, 4'd4, "R7 imm and");
        drive(4'd0, 6'h00, 5'd0, 32'h0, 32'h0, 6'h0D, 32'h0, 1'b0, 4'd5, "R7 imm or");
        drive(4'd0, 6'h00, 5'd0, 32'h0, 32'h0, 6'h09, 32'h0, 1'b0, 4'd0, "R7 imm unknown");
        // R8 unknown funct
        drive(4'd1, 6'h21, 5'd0, 32'h5, 32'h6, 6'h00, 32'h0, 1'b1, 4'd0, "R8 funct 0x21");
        drive(4'd1, 6'h08, 5'd0, 32'h5, 32'h6, 6'h00, 32'h0, 1'b1, 4'd0, "R8 funct 0x08");
        drive(4'd1, 6'h03, 5'd2, 32'h5, 32'hF0, 6'h00, 32'h0, 1'b1, 4'd0, "R8 funct 0x03");
        // R9 unused master codes
        for (int m = 11; m < 16; m++)
            drive(4'(m), 6'h20, 5'd0, 32'h5, 32'h6, 6'h00, 32'h0, 1'b1, 4'd0, "R9 unused master code");
        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule